// File: doc/BRIEF.md
# Floating-Point Status and Control Register

This block is the 32-bit status and control word that sits beside a floating-point datapath. Software reads it and writes its control fields through a simple CPU-side port. The datapath drives the other side. It sends a strobe at the start of every floating-point instruction, one event pulse per exception class, and a flag that marks a denormal operand.

The register holds the rounding-mode field, the flush-to-zero control, five trap-enable bits and six cause bits. The cause bits record which exceptions the current instruction raised. The start strobe of the next instruction wipes them. Software can clear any of them by writing 0, and a written 1 leaves them as they are. The block presents the rounding mode and the flush control to the datapath. It also raises a one-cycle trap request when an exception arrives whose trap is enabled.

Top module: `fpsr_unit`

## Requirements
- R1: After reset, the read value is 0x0000_0000: round-to-nearest, flush-to-zero off, all traps masked, no cause bit set. The trap request is low.
- R2: Bits 31:30 hold the rounding mode, with 00 = nearest, 01 = toward zero, 10 = toward +infinity and 11 = toward -infinity. The field is written on a CPU write, reads back, and drives `round_mode` from the cycle after the write.
- R3: Bit 23 (flush-to-zero) and bits 21:17 (trap enables: 17 inexact, 18 underflow, 19 divide-by-zero, 20 overflow, 21 invalid) are read/write. Bit 22 and bits 16:0 always read 0, whatever was written.
- R4: An event pulse sets its cause bit in the next cycle. The cause bits are 24 unimplemented, 25 inexact, 26 underflow, 27 divide-by-zero, 28 overflow and 29 invalid.
- R5: An `op_start` pulse clears every cause bit in the next cycle.
- R6: A CPU write clears each cause bit whose written bit is 0. A cause bit whose written bit is 1 keeps its value.
- R7: An event in the same cycle as `op_start` or a clearing write leaves its cause bit set.
- R8: A `denorm_in` pulse raises the unimplemented-operation event when flush-to-zero is 0. When flush-to-zero is 1, it has no effect. `flush_zero` mirrors bit 23.
- R9: `trap_req` is high in the cycle after a group of events when at least one of them is enabled. Unimplemented is always enabled, and an enabled event among masked ones is enough. If every event in the group is masked, `trap_req` stays low.
- R10: `trap_req` lasts a single cycle. It drops in the following cycle unless new enabled events arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | CPU write strobe |
| wr_data | input | 32 | CPU write data |
| rd_data | output | 32 | Current register value |
| op_start | input | 1 | Start of a floating-point instruction |
| exc_unimpl | input | 1 | Unimplemented-operation event |
| exc_inexact | input | 1 | Inexact event |
| exc_underflow | input | 1 | Underflow event |
| exc_divzero | input | 1 | Divide-by-zero event |
| exc_overflow | input | 1 | Overflow event |
| exc_invalid | input | 1 | Invalid-operation event |
| denorm_in | input | 1 | Denormal operand seen |
| round_mode | output | 2 | Current rounding mode |
| flush_zero | output | 1 | Flush-to-zero control |
| trap_req | output | 1 | One-cycle trap request |

## Verification
The bench targets the cycles where an event pulse meets `op_start` or a clearing write. A design that lets the clear win would lose a cause bit that the running instruction has just raised. An all-ones write checks that cause bits ignore written 1s and that bit 22 and the low bits stay 0. A design that loads the cause field or stores the reserved bits would read back 1s there. The bench also pairs an enabled event with a masked one and sends denormal operands under both flush settings. This exposes an AND-style trap combine, a masked unimplemented trap, and a denormal that sets the cause bit when flush-to-zero is on. Random traffic under a fixed seed covers the remaining mixes.

// File: rtl/fpsr_pkg.sv
package fpsr_pkg;
  localparam int REG_W     = 32;
  localparam int EXC_N     = 6;   // [0] unimpl, [1] inexact, [2] underflow, [3] divzero, [4] overflow, [5] invalid
  localparam int EN_N      = EXC_N - 1;
  localparam int EN_LSB    = 17;
  localparam int RSV_BIT   = 22;
  localparam int FTZ_BIT   = 23;
  localparam int CAUSE_LSB = 24;
  localparam int RM_LSB    = 30;
  localparam int RM_W      = 2;

  typedef enum logic [RM_W-1:0] {
    RM_NEAREST = 2'b00,
    RM_ZERO    = 2'b01,
    RM_POS_INF = 2'b10,
    RM_NEG_INF = 2'b11
  } rmode_t;

  // Next cause vector: start clears, a write keeps only bits written as 1,
  // and a hardware set always wins.
  function automatic logic [EXC_N-1:0] cause_step(
    input logic [EXC_N-1:0] cur,
    input logic             start,
    input logic             wr,
    input logic [EXC_N-1:0] wbits,
    input logic [EXC_N-1:0] set
  );
    logic [EXC_N-1:0] keep;
    keep = start ? '0 : cur;
    if (wr) keep = keep & wbits;
    return keep | set;
  endfunction

  // Trap decision: unimplemented is always enabled.
  function automatic logic trap_hit(
    input logic [EXC_N-1:0] set,
    input logic [EN_N-1:0]  en
  );
    return |(set & {en, 1'b1});
  endfunction
endpackage

// File: rtl/fpsr_ctrl.sv
module fpsr_ctrl
  import fpsr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output rmode_t           rm_q,
  output logic             ftz_q,
  output logic [EN_N-1:0]  en_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rm_q  <= RM_NEAREST;
      ftz_q <= 1'b0;
      en_q  <= '0;
    end else if (wr_en) begin
      rm_q  <= rmode_t'(wr_data[RM_LSB +: RM_W]);
      ftz_q <= wr_data[FTZ_BIT];
      en_q  <= wr_data[EN_LSB +: EN_N];
    end
  end
endmodule

// File: rtl/fpsr_cause.sv
module fpsr_cause
  import fpsr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             wr_en,
  input  logic [EXC_N-1:0] wr_bits,
  input  logic [EXC_N-1:0] set,
  output logic [EXC_N-1:0] cause_q
);
  logic [EXC_N-1:0] cause_d;

  always_comb cause_d = cause_step(cause_q, start, wr_en, wr_bits, set);

  for (genvar i = 0; i < EXC_N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) cause_q[i] <= 1'b0;
      else        cause_q[i] <= cause_d[i];
    end
  end
endmodule

// File: rtl/fpsr_trap.sv
module fpsr_trap
  import fpsr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EXC_N-1:0] set,
  input  logic [EN_N-1:0]  en,
  output logic             trap_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) trap_q <= 1'b0;
    else        trap_q <= trap_hit(set, en);
  end
endmodule

// File: rtl/fpsr_unit.sv
module fpsr_unit
  import fpsr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  input  logic        op_start,
  input  logic        exc_unimpl,
  input  logic        exc_inexact,
  input  logic        exc_underflow,
  input  logic        exc_divzero,
  input  logic        exc_overflow,
  input  logic        exc_invalid,
  input  logic        denorm_in,
  output logic [1:0]  round_mode,
  output logic        flush_zero,
  output logic        trap_req
);
  rmode_t           rm_q;
  logic             ftz_q;
  logic [EN_N-1:0]  en_q;
  logic [EXC_N-1:0] cause_q;
  logic [EXC_N-1:0] hw_set;
  logic             denorm_fault;

  assign denorm_fault = denorm_in & ~ftz_q;
  assign hw_set = {exc_invalid, exc_overflow, exc_divzero,
                   exc_underflow, exc_inexact, exc_unimpl | denorm_fault};

  fpsr_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rm_q(rm_q), .ftz_q(ftz_q), .en_q(en_q)
  );

  fpsr_cause u_cause (
    .clk(clk), .rst_n(rst_n), .start(op_start), .wr_en(wr_en),
    .wr_bits(wr_data[CAUSE_LSB +: EXC_N]), .set(hw_set), .cause_q(cause_q)
  );

  fpsr_trap u_trap (
    .clk(clk), .rst_n(rst_n), .set(hw_set), .en(en_q), .trap_q(trap_req)
  );

  always_comb begin
    rd_data = '0;
    rd_data[RM_LSB +: RM_W]     = rm_q;
    rd_data[CAUSE_LSB +: EXC_N] = cause_q;
    rd_data[FTZ_BIT]            = ftz_q;
    rd_data[EN_LSB +: EN_N]     = en_q;
  end

  assign round_mode = rm_q;
  assign flush_zero = ftz_q;
endmodule

// File: rtl/fpsr_checker.sv
module fpsr_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic [31:0] rd_data,
  input logic        op_start,
  input logic        denorm_in,
  input logic        flush_zero,
  input logic        exc_unimpl,
  input logic [5:0]  hw_set,
  input logic        trap_req
);
  p_reserved_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[22] == 1'b0) && (rd_data[16:0] == 17'd0));

  p_event_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_set != 6'd0) |=> ((rd_data[29:24] & $past(hw_set)) == $past(hw_set)));

  p_start_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_start && hw_set == 6'd0) |=> (rd_data[29:24] == 6'd0));

  p_write_one_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !op_start) |=>
      (rd_data[29:24] == (($past(rd_data[29:24]) & $past(wr_data[29:24])) | $past(hw_set))));

  p_denorm_fault_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (denorm_in && !flush_zero) |-> hw_set[0]);

  p_denorm_flushed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_zero && !exc_unimpl) |-> !hw_set[0]);

  p_trap_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_set[0]) |=> trap_req);

  p_trap_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_set == 6'd0) |=> !trap_req);
endmodule

bind fpsr_unit fpsr_checker u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .op_start(op_start), .denorm_in(denorm_in),
  .flush_zero(flush_zero), .exc_unimpl(exc_unimpl), .hw_set(hw_set),
  .trap_req(trap_req)
);

// File: tb/sim_fpsr_unit.sv
`timescale 1ns/1ps
module sim_fpsr_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        op_start = 1'b0;
  logic [5:0]  ev = '0;
  logic        denorm_in = 1'b0;
  logic [1:0]  round_mode;
  logic        flush_zero;
  logic        trap_req;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model
  logic [1:0] m_rm = '0;
  logic       m_ftz = 1'b0;
  logic [4:0] m_en = '0;
  logic [5:0] m_cause = '0;
  logic       m_trap = 1'b0;

  always #5 clk = ~clk;

  fpsr_unit u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .op_start(op_start), .exc_unimpl(ev[0]), .exc_inexact(ev[1]),
    .exc_underflow(ev[2]), .exc_divzero(ev[3]), .exc_overflow(ev[4]),
    .exc_invalid(ev[5]), .denorm_in(denorm_in), .round_mode(round_mode),
    .flush_zero(flush_zero), .trap_req(trap_req)
  );

  function automatic logic [31:0] model_word();
    logic [31:0] w;
    w = 32'd0;
    w[31:30] = m_rm;
    for (int i = 0; i < 6; i++) w[24+i] = m_cause[i];
    w[23] = m_ftz;
    for (int i = 0; i < 5; i++) w[17+i] = m_en[i];
    return w;
  endfunction

  task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic we, input logic [31:0] wd, input logic st,
                     input logic [5:0] e, input logic dn, input string tag);
    logic [5:0] set;
    logic [5:0] nc;
    logic       nt;
    wr_en = we; wr_data = wd; op_start = st; ev = e; denorm_in = dn;
    set = e;
    if (dn && !m_ftz) set[0] = 1'b1;
    nt = 1'b0;
    for (int i = 0; i < 6; i++) begin
      logic keep;
      keep = m_cause[i];
      if (st) keep = 1'b0;
      if (we && !wd[24+i]) keep = 1'b0;
      nc[i] = keep | set[i];
      if (set[i] && (i == 0 || m_en[i-1])) nt = 1'b1;
    end
    @(posedge clk);
    #2;
    m_cause = nc;
    m_trap = nt;
    if (we) begin
      m_rm = wd[31:30];
      m_ftz = wd[23];
      m_en = wd[21:17];
    end
    check32(tag, rd_data, model_word());
    check32("R9 R10 trap", {31'd0, trap_req}, {31'd0, m_trap});
    check32("R2 round_mode", {30'd0, round_mode}, {30'd0, m_rm});
    check32("R8 flush_zero", {31'd0, flush_zero}, {31'd0, m_ftz});
    wr_en = 1'b0; op_start = 1'b0; ev = '0; denorm_in = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    seed = 32'd1234;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    check32("R1 reset word", rd_data, 32'd0);
    check32("R1 reset trap", {31'd0, trap_req}, 32'd0);
    // R3: all-ones write, cause ignores 1s, reserved bits stay 0
    cyc(1, 32'hFFFF_FFFF, 0, 6'd0, 0, "R3 all-ones write");
    // R2 each rounding mode
    for (int r = 0; r < 4; r++) cyc(1, {r[1:0], 30'd0}, 0, 6'd0, 0, "R2 rounding mode");
    cyc(1, 32'd0, 0, 6'd0, 0, "R1 clear");
    // R4, R9 masked
    cyc(0, 0, 0, 6'b000010, 0, "R4 inexact set masked");
    // R9 mixed: enable overflow only, raise overflow+underflow
    cyc(1, 32'h0010_0000 | 32'h0200_0000, 0, 6'd0, 0, "R6 keep via write 1");
    cyc(0, 0, 0, 6'b010100, 0, "R9 mixed enables");
    cyc(0, 0, 0, 6'd0, 0, "R10 trap drops");
    cyc(1, 32'h0010_0000, 0, 6'd0, 0, "R6 write 0 clears");
    cyc(0, 0, 0, 6'b101000, 0, "R4 set two");
    cyc(0, 0, 1, 6'd0, 0, "R5 start clears");
    cyc(0, 0, 1, 6'b000100, 0, "R7 start with event");
    cyc(1, 32'h0010_0000, 0, 6'b000100, 0, "R7 write 0 with event");
    cyc(1, 32'd0, 0, 6'd0, 0, "R6 clear all");
    cyc(0, 0, 0, 6'd0, 1, "R8 denorm no flush");
    cyc(1, 32'h0080_0000, 0, 6'd0, 0, "R8 enable flush");
    cyc(0, 0, 0, 6'd0, 1, "R8 denorm flushed");
    cyc(0, 0, 0, 6'b100000, 0, "R9 invalid masked");
    for (int k = 0; k < 600; k++) begin
      logic we, st, dn;
      logic [5:0] e;
      logic [31:0] wd;
      we = ($urandom % 5) == 0;
      st = ($urandom % 4) == 0;
      dn = ($urandom % 6) == 0;
      e  = (($urandom % 3) == 0) ? 6'($urandom) : 6'd0;
      wd = $urandom;
      cyc(we, wd, st, e, dn, "R4 R5 R6 R7 random");
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule